// File: doc/BRIEF.md
# Packed horizontal pairwise adder

This SIMD datapath unit takes two packed operands and reduces each one by adding neighbouring elements in pairs. The sums from the first operand fill the low half of each 128-bit lane of the result, and the sums from the second operand fill the high half. Elements are 16 or 32 bits wide. Operands are 64, 128 or 256 bits wide. In 256-bit mode the two 128-bit lanes are handled independently.

Every sum wraps modulo the element width. No saturation, carry or overflow is reported, so one adder serves signed and unsigned data. For 128-bit operation, a keep flag decides whether result bits 255:128 copy a supplied previous-destination value or are cleared.

Operands and controls enter through a valid/ready handshake. The result leaves one clock later from a single output register with its own valid/ready pair.

Top module: `hpair_add`

## Requirements
- R1: With `elem_sel_i`=0 (16-bit) and `width_sel_i`=1 (128-bit), result word j (bits 16j+15:16j) is `opa_i` word 2j plus word 2j+1 for j=0..3. For j=4..7 it is `opb_i` word 2(j-4) plus word 2(j-4)+1.
- R2: With `elem_sel_i`=1 (32-bit) and `width_sel_i`=1, result dwords 0 and 1 are `opa_i` dword pairs (0,1) and (2,3). Dwords 2 and 3 are the same pairs of `opb_i`.
- R3: With `width_sel_i`=0 (64-bit) and 16-bit elements, bits 31:0 hold the sums of `opa_i` word pairs (0,1) and (2,3). Bits 63:32 hold the same sums of `opb_i`. Bits 255:64 are zero.
- R4: With `width_sel_i`=0 and 32-bit elements, bits 31:0 are `opa_i` dword0+dword1 and bits 63:32 are `opb_i` dword0+dword1. Bits 255:64 are zero.
- R5: With `width_sel_i`=2 or 3 (256-bit), bits 127:0 follow the 128-bit rule on operand bits 127:0. Bits 255:128 follow the same rule using only operand bits 255:128.
- R6: Sums wrap modulo the element width with no saturation. For example, 0x7FFF+0x0001 gives 0x8000, 0xFFFF+0x0001 gives 0x0000, and 0xFFFFFFFF+0x00000001 gives 0.
- R7: In 128-bit mode with `keep_hi_i`=1, result bits 255:128 equal the `prev_hi_i` value presented at acceptance.
- R8: In 128-bit mode with `keep_hi_i`=0, result bits 255:128 are zero. In 64-bit and 256-bit modes, `keep_hi_i` and `prev_hi_i` have no effect on the result.
- R9: An input is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both high. After that edge, `out_valid_o` is high and `res_o` carries its result.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `res_o` and `out_valid_o` hold and `in_ready_o` is low. With `out_ready_i` high, a new input is accepted in the same cycle that the held result drains.
- R11: While `rst_ni` is low and after its release, `out_valid_o` is low and `in_ready_o` is high until the first acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operands and controls valid |
| in_ready_o | output | 1 | Unit can accept an input |
| elem_sel_i | input | 1 | 0: 16-bit elements, 1: 32-bit elements |
| width_sel_i | input | 2 | 0: 64-bit, 1: 128-bit, 2 or 3: 256-bit |
| keep_hi_i | input | 1 | 128-bit mode: keep upper bits from prev_hi_i |
| opa_i | input | 256 | First packed operand |
| opb_i | input | 256 | Second packed operand |
| prev_hi_i | input | 128 | Previous destination bits 255:128 |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream takes the result |
| res_o | output | 256 | Packed result |

## Verification
Two events can fall in the same cycle: a new input can be accepted while the held result drains, and a waiting input can be refused while the result is stalled. The bench presents two back-to-back inputs with `out_ready_i` high and expects both results in order, with nothing lost or repeated. It then holds `out_ready_i` low while a second input waits. It checks that `in_ready_o` stays low and `res_o` stays frozen. When `out_ready_i` returns high, the drain and the next acceptance happen on the same edge, and the bench expects the second result one cycle later.

// File: rtl/hpair_pkg.sv
package hpair_pkg;
  typedef enum logic [1:0] {
    VW_NARROW = 2'd0,
    VW_SINGLE = 2'd1,
    VW_DUAL   = 2'd2,
    VW_DUAL_X = 2'd3
  } vw_e;

  typedef enum logic {
    ES_WORD  = 1'b0,
    ES_DWORD = 1'b1
  } es_e;
endpackage

// File: rtl/hpair_lane.sv
// Pairwise sums of one lane: opa sums to low half, opb sums to high half.
module hpair_lane #(
  parameter int LANE_W = 128,
  parameter int ELEM_W = 16
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] sum_o
);
  localparam int PAIRS = LANE_W / (2 * ELEM_W);

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign sum_o[k*ELEM_W +: ELEM_W] =
        a_i[(2*k)*ELEM_W +: ELEM_W] + a_i[(2*k+1)*ELEM_W +: ELEM_W];
    assign sum_o[(PAIRS+k)*ELEM_W +: ELEM_W] =
        b_i[(2*k)*ELEM_W +: ELEM_W] + b_i[(2*k+1)*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/hpair_sel.sv
module hpair_sel
  import hpair_pkg::*;
#(
  parameter int LANE_W    = 128,
  parameter int NUM_LANES = 2,
  localparam int VEC_W    = LANE_W * NUM_LANES,
  localparam int NAR_W    = LANE_W / 2,
  localparam int HI_W     = VEC_W - LANE_W
) (
  input  es_e              es_i,
  input  vw_e              vw_i,
  input  logic             keep_i,
  input  logic [VEC_W-1:0] wide_w_i,
  input  logic [VEC_W-1:0] wide_d_i,
  input  logic [NAR_W-1:0] nar_w_i,
  input  logic [NAR_W-1:0] nar_d_i,
  input  logic [HI_W-1:0]  prev_hi_i,
  output logic [VEC_W-1:0] res_o
);
  logic [VEC_W-1:0] wide;
  logic [NAR_W-1:0] nar;

  assign wide = (es_i == ES_DWORD) ? wide_d_i : wide_w_i;
  assign nar  = (es_i == ES_DWORD) ? nar_d_i  : nar_w_i;

  always_comb begin
    res_o = '0;
    unique case (vw_i)
      VW_NARROW: res_o[NAR_W-1:0] = nar;
      VW_SINGLE: begin
        res_o[LANE_W-1:0]     = wide[LANE_W-1:0];
        res_o[VEC_W-1:LANE_W] = keep_i ? prev_hi_i : '0;
      end
      default:   res_o = wide;
    endcase
  end
endmodule

// File: rtl/hpair_oreg.sv
module hpair_oreg #(
  parameter int W = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] d_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] q_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready_o  = !vld_q || out_ready_i;
  assign out_valid_o = vld_q;
  assign q_o         = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) dat_q <= d_i;
    end
  end

  // R9
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (out_valid_o && q_o == $past(d_i)));

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(q_o)));

  // R10
  stall_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
endmodule

// File: rtl/hpair_add.sv
module hpair_add
  import hpair_pkg::*;
#(
  parameter int LANE_W    = 128,
  parameter int NUM_LANES = 2,
  localparam int VEC_W    = LANE_W * NUM_LANES,
  localparam int NAR_W    = LANE_W / 2,
  localparam int HI_W     = VEC_W - LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             elem_sel_i,
  input  logic [1:0]       width_sel_i,
  input  logic             keep_hi_i,
  input  logic [VEC_W-1:0] opa_i,
  input  logic [VEC_W-1:0] opb_i,
  input  logic [HI_W-1:0]  prev_hi_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [VEC_W-1:0] res_o
);
  logic [VEC_W-1:0] wide_w, wide_d, res_c;
  logic [NAR_W-1:0] nar_w, nar_d;
  es_e es;
  vw_e vw;

  assign es = es_e'(elem_sel_i);
  assign vw = vw_e'(width_sel_i);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    hpair_lane #(.LANE_W(LANE_W), .ELEM_W(16)) u_w (
      .a_i  (opa_i[l*LANE_W +: LANE_W]),
      .b_i  (opb_i[l*LANE_W +: LANE_W]),
      .sum_o(wide_w[l*LANE_W +: LANE_W])
    );
    hpair_lane #(.LANE_W(LANE_W), .ELEM_W(32)) u_d (
      .a_i  (opa_i[l*LANE_W +: LANE_W]),
      .b_i  (opb_i[l*LANE_W +: LANE_W]),
      .sum_o(wide_d[l*LANE_W +: LANE_W])
    );
  end

  hpair_lane #(.LANE_W(NAR_W), .ELEM_W(16)) u_nar_w (
    .a_i(opa_i[NAR_W-1:0]), .b_i(opb_i[NAR_W-1:0]), .sum_o(nar_w)
  );
  hpair_lane #(.LANE_W(NAR_W), .ELEM_W(32)) u_nar_d (
    .a_i(opa_i[NAR_W-1:0]), .b_i(opb_i[NAR_W-1:0]), .sum_o(nar_d)
  );

  hpair_sel #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_sel (
    .es_i     (es),
    .vw_i     (vw),
    .keep_i   (keep_hi_i),
    .wide_w_i (wide_w),
    .wide_d_i (wide_d),
    .nar_w_i  (nar_w),
    .nar_d_i  (nar_d),
    .prev_hi_i(prev_hi_i),
    .res_o    (res_c)
  );

  hpair_oreg #(.W(VEC_W)) u_oreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .d_i        (res_c),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .q_o        (res_o)
  );

  logic accept;
  assign accept = in_valid_i && in_ready_o;

  // R3
  narrow_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && width_sel_i == 2'd0) |=> (res_o[VEC_W-1:NAR_W] == '0));

  // R7
  keep_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && width_sel_i == 2'd1 && keep_hi_i)
      |=> (res_o[VEC_W-1:LANE_W] == $past(prev_hi_i)));

  // R8
  clear_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && width_sel_i == 2'd1 && !keep_hi_i)
      |=> (res_o[VEC_W-1:LANE_W] == '0));

  // R11
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !out_valid_o);
endmodule

// File: tb/sim_hpair_add.sv
module sim_hpair_add;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         elem_sel = 1'b0;
  logic [1:0]   width_sel = 2'd0;
  logic         keep_hi = 1'b0;
  logic [255:0] opa = '0, opb = '0;
  logic [127:0] prev_hi = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] res;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpair_add u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .elem_sel_i(elem_sel), .width_sel_i(width_sel), .keep_hi_i(keep_hi),
    .opa_i(opa), .opb_i(opb), .prev_hi_i(prev_hi),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .res_o(res)
  );

  typedef struct packed {
    logic        es;
    logic [1:0]  vw;
    logic        keep;
    logic [31:0] seed;
  } vec_t;

  localparam int N_VEC = 10;
  localparam vec_t VEC [N_VEC] = '{
    '{1'b0, 2'd1, 1'b0, 32'h0000_1234},  // R1
    '{1'b0, 2'd1, 1'b1, 32'h8765_4321},  // R1 R7
    '{1'b1, 2'd1, 1'b0, 32'h0BAD_F00D},  // R2
    '{1'b1, 2'd1, 1'b1, 32'hFFFF_0001},  // R2 R7
    '{1'b0, 2'd0, 1'b1, 32'h1357_9BDF},  // R3 R8
    '{1'b1, 2'd0, 1'b0, 32'h2468_ACE0},  // R4
    '{1'b0, 2'd2, 1'b1, 32'h5555_AAAA},  // R5 R8
    '{1'b1, 2'd2, 1'b0, 32'h7FFF_FFFF},  // R5
    '{1'b0, 2'd3, 1'b0, 32'h0F0F_F0F0},  // R5 code 3
    '{1'b1, 2'd3, 1'b1, 32'hC001_D00D}   // R5 R8
  };

  function automatic logic [255:0] gen(input logic [31:0] seed, input logic [31:0] salt);
    logic [255:0] v;
    logic [31:0]  x;
    x = seed ^ salt;
    for (int i = 0; i < 8; i++) begin
      x = x * 32'h9E37_79B1 + 32'h7F4A_7C15;
      v[i*32 +: 32] = x ^ (x >> 13);
    end
    return v;
  endfunction

  // Behavioural reference
  function automatic logic [255:0] model(input logic es, input logic [1:0] vw, input logic keep,
                                         input logic [255:0] a, input logic [255:0] b,
                                         input logic [127:0] prev);
    logic [255:0] r;
    int lanes, lw, ne;
    r = '0;
    lanes = (vw >= 2'd2) ? 2 : 1;
    lw    = (vw == 2'd0) ? 64 : 128;
    ne    = lw / (es ? 32 : 16);
    for (int l = 0; l < lanes; l++) begin
      for (int j = 0; j < ne/2; j++) begin
        if (!es) begin
          r[l*lw + j*16 +: 16]        = a[l*lw + 2*j*16 +: 16] + a[l*lw + (2*j+1)*16 +: 16];
          r[l*lw + (ne/2+j)*16 +: 16] = b[l*lw + 2*j*16 +: 16] + b[l*lw + (2*j+1)*16 +: 16];
        end else begin
          r[l*lw + j*32 +: 32]        = a[l*lw + 2*j*32 +: 32] + a[l*lw + (2*j+1)*32 +: 32];
          r[l*lw + (ne/2+j)*32 +: 32] = b[l*lw + 2*j*32 +: 32] + b[l*lw + (2*j+1)*32 +: 32];
        end
      end
    end
    if (vw == 2'd1 && keep) r[255:128] = prev;
    return r;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic es, input logic [1:0] vw, input logic keep,
                       input logic [255:0] a, input logic [255:0] b, input logic [127:0] p);
    in_valid = 1'b1; elem_sel = es; width_sel = vw; keep_hi = keep;
    opa = a; opb = b; prev_hi = p;
  endtask

  task automatic run_one(input string req, input logic es, input logic [1:0] vw, input logic keep,
                         input logic [255:0] a, input logic [255:0] b, input logic [127:0] p);
    @(negedge clk);
    drive(es, vw, keep, a, b, p);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {255'd0, out_valid}, 256'd1);
    check(req, res, model(es, vw, keep, a, b, p));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [255:0] a1, b1, a2, b2, e1, e2;
    logic [127:0] p1;

    // R11 reset state
    #(CLK_PERIOD * 2 + 2);
    check("R11 out_valid in reset", {255'd0, out_valid}, 256'd0);
    check("R11 in_ready in reset", {255'd0, in_ready}, 256'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", {255'd0, out_valid}, 256'd0);

    // Table walk: R1 R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < N_VEC; i++) begin
      run_one("R9 table", VEC[i].es, VEC[i].vw, VEC[i].keep,
              gen(VEC[i].seed, 32'hA5A5_0000), gen(VEC[i].seed, 32'h0000_5A5A),
              gen(VEC[i].seed, 32'h1111_2222)[127:0]);
    end

    // R6 wrap: words 0x7FFF+0x0001, 0xFFFF+0x0001
    a1 = '0; a1[31:0] = 32'h0001_7FFF; a1[63:32] = 32'h0001_FFFF;
    b1 = '0; b1[31:0] = 32'h8000_8000;
    run_one("R6 word wrap", 1'b0, 2'd1, 1'b0, a1, b1, '0);
    check("R6 word0 0x8000", {240'd0, res[15:0]}, 256'h8000);
    check("R6 word1 0x0000", {240'd0, res[31:16]}, 256'h0000);
    check("R6 word4 0x0000", {240'd0, res[79:64]}, 256'h0000);
    // R6 dword wrap
    a1 = '0; a1[63:0] = 64'h0000_0001_FFFF_FFFF;
    run_one("R6 dword wrap", 1'b1, 2'd1, 1'b0, a1, '0, '0);
    check("R6 dword0 0", {224'd0, res[31:0]}, 256'd0);

    // R3 explicit field positions, upper bits zero despite keep
    a1 = {256{1'b1}}; a1[63:0] = 64'h0004_0003_0002_0001;
    b1 = {256{1'b1}}; b1[63:0] = 64'h0040_0030_0020_0010;
    run_one("R3 narrow word", 1'b0, 2'd0, 1'b1, a1, b1, {128{1'b1}});
    check("R3 narrow word exact", res, {192'd0, 64'h0070_0030_0007_0003});
    // R4
    a1 = '0; a1[63:0] = 64'h0000_0010_0000_0005;
    b1 = '0; b1[63:0] = 64'h0000_0100_0000_0200;
    run_one("R4 narrow dword", 1'b1, 2'd0, 1'b1, a1, b1, {128{1'b1}});
    check("R4 narrow dword exact", res, {192'd0, 64'h0000_0300_0000_0015});

    // R7 / R8 keep vs clear, same operands
    a1 = gen(32'h42, 32'h1); b1 = gen(32'h43, 32'h2); p1 = gen(32'h44, 32'h3)[127:0];
    run_one("R7 keep", 1'b0, 2'd1, 1'b1, a1, b1, p1);
    check("R7 upper = prev", {128'd0, res[255:128]}, {128'd0, p1});
    run_one("R8 clear", 1'b0, 2'd1, 1'b0, a1, b1, p1);
    check("R8 upper zero", {128'd0, res[255:128]}, 256'd0);
    // R8 keep ignored in 256-bit mode
    run_one("R8 dual keep ignored", 1'b1, 2'd2, 1'b1, a1, b1, p1);
    check("R8 dual keep ignored", res, model(1'b1, 2'd2, 1'b0, a1, b1, '0));

    // R10 back-to-back: accept while draining
    a1 = gen(32'h100, 32'h7); b1 = gen(32'h101, 32'h7);
    a2 = gen(32'h200, 32'h9); b2 = gen(32'h201, 32'h9);
    e1 = model(1'b0, 2'd2, 1'b0, a1, b1, '0);
    e2 = model(1'b1, 2'd1, 1'b0, a2, b2, '0);
    @(negedge clk); drive(1'b0, 2'd2, 1'b0, a1, b1, '0);
    @(negedge clk);
    check("R10 b2b in_ready", {255'd0, in_ready}, 256'd1);
    check("R10 b2b first", res, e1);
    drive(1'b1, 2'd1, 1'b0, a2, b2, '0);
    @(negedge clk); in_valid = 1'b0;
    check("R10 b2b second valid", {255'd0, out_valid}, 256'd1);
    check("R10 b2b second", res, e2);
    @(negedge clk);
    check("R10 drained", {255'd0, out_valid}, 256'd0);

    // R10 stall: second input waits
    out_ready = 1'b0;
    drive(1'b0, 2'd2, 1'b0, a1, b1, '0);
    @(negedge clk);
    drive(1'b1, 2'd1, 1'b0, a2, b2, '0);
    #1;
    check("R10 stall in_ready low", {255'd0, in_ready}, 256'd0);
    check("R10 stall first", res, e1);
    @(negedge clk);
    check("R10 stall held valid", {255'd0, out_valid}, 256'd1);
    check("R10 stall held data", res, e1);
    check("R10 stall still not ready", {255'd0, in_ready}, 256'd0);
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R10 after stall second", res, e2);
    check("R10 after stall valid", {255'd0, out_valid}, 256'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule